// File: doc/BRIEF.md
# Frame-Indexed Interrupt Polling Scheduler

This block paces periodic interrupt service for a host controller. A 16-bit frame counter advances on every 1 ms frame-start pulse. For each new frame the block forms the byte address of one entry in a 32-entry table of 32-bit list-head pointers kept in shared memory. It then raises a single-beat read request for that entry and holds it until the memory side acknowledges it. The table start comes from a programmable base register. The low five bits of the frame number pick the entry, so every entry is visited once per 32 frames.

Alongside the address, the block keeps a small local table of interrupt endpoints. Each endpoint has a power-of-two polling interval (1 to 32 frames) and a phase. Once per frame the block presents a vector with one bit per endpoint, showing which endpoints are due in that frame. It also gives the bit-reversed slot index, which is the leaf position of the current slot in the balanced polling tree. Endpoints that share an interval but have different phases therefore land in frames spread evenly apart. Walking the fetched lists and running bus transfers are left to other blocks.

Top module: `pollSched`

## Requirements
- R1: After reset, frameNum is 0, rdReq, dueValid and dueVec are 0, the base register is 0, and every endpoint entry holds interval code 7 (disabled).
- R2: A frameTick sampled high at a clock edge makes frameNum one larger at that edge, modulo 2^16; frameNum does not change otherwise. Ticks on consecutive cycles each count.
- R3: For each sampled frameTick, dueValid is high for the single cycle that follows the next clock edge, which is the cycle after frameNum has incremented. dueVec reads 0 whenever dueValid is low.
- R4: The read address given with a request is {base[31:7], frameNum[4:0], 2'b00}, using the incremented frame number. Bits [6:0] written to the base register have no effect on any address.
- R5: rdReq rises in the same cycle as dueValid. It stays high with rdAddr unchanged until rdAck is sampled high at a clock edge, and it is low after that edge.
- R6: If a new request is launched while the previous one is still pending, rdReq stays high and rdAddr moves to the entry of the new frame.
- R7: An endpoint with interval code k (0..5, interval 2^k frames) and phase p is due in a frame f when f[k-1:0] equals p[k-1:0]. Code 0 is due every frame. Phase bits at position k and above are ignored.
- R8: An endpoint with interval code 6 or 7 is never due.
- R9: leafPos, shown together with each request, is frameNum[4:0] with its bit order reversed (bit 0 moves to bit 4).
- R10: An endpoint write (epWrEn with epWrIdx, epWrInterval, epWrPhase) replaces that entry. It applies to every due vector captured after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-cycle frame-start pulse |
| baseWrEn | input | 1 | Load the base register |
| baseWrData | input | 32 | New base value (low 7 bits ignored) |
| epWrEn | input | 1 | Write one endpoint entry |
| epWrIdx | input | 3 | Endpoint entry index |
| epWrInterval | input | 3 | Interval code, 2^code frames; 6 and 7 disable |
| epWrPhase | input | 5 | Phase within the interval |
| rdAck | input | 1 | Memory accepts the pending read |
| rdReq | output | 1 | Head-pointer read request |
| rdAddr | output | 32 | Byte address of the head-pointer entry |
| leafPos | output | 5 | Bit-reversed slot index of the current frame |
| frameNum | output | 16 | Current frame number |
| dueValid | output | 1 | dueVec is valid this cycle |
| dueVec | output | 8 | One bit per endpoint, high when due |

## Verification
The bench targets the endpoint mix over 64 frames. That mix covers all six interval codes and both disabled codes, with phases that carry bits above the interval width. A design that masked the wrong number of bits would show a due pattern shifted or repeated at the wrong rate. A design that decoded codes 6 and 7 would report disabled endpoints as due. The bench also checks the address with a base whose low bits are set, the slot order through bit reversal, and a request that is replaced before it is acknowledged. A design that got any of these wrong would fetch an unaligned or stale entry, or drop the request. Finally, a burst of back-to-back ticks carries the counter through its wrap. A design that saturated the counter or skipped a tick would not read frame 0 at the end of the burst.

// File: rtl/pollPkg.sv
package pollPkg;
  localparam int SLOT_BITS = 5;
  localparam int CODE_W    = 3;
  localparam int MAX_CODE  = SLOT_BITS;

  typedef struct packed {
    logic incFrame;
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameTick,
  input  logic         rdAck,
  output ctrlStrobes_t strobes,
  output logic         rdReq,
  output logic         dueValid
);
  logic launchQ;

  always_comb begin
    strobes.incFrame = frameTick;
    strobes.capture  = launchQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      launchQ  <= 1'b0;
      dueValid <= 1'b0;
      rdReq    <= 1'b0;
    end else begin
      launchQ  <= frameTick;
      dueValid <= launchQ;
      if (launchQ) rdReq <= 1'b1;
      else if (rdAck) rdReq <= 1'b0;
    end
  end
endmodule

// File: rtl/pollDueTable.sv
module pollDueTable
  import pollPkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 epWrEn,
  input  logic [IDX_W-1:0]     epWrIdx,
  input  logic [CODE_W-1:0]    epWrInterval,
  input  logic [SLOT_BITS-1:0] epWrPhase,
  input  logic [SLOT_BITS-1:0] frameSlot,
  output logic [NUM_EP-1:0]    dueNow
);
  logic [CODE_W-1:0]    intervalQ [NUM_EP];
  logic [SLOT_BITS-1:0] phaseQ    [NUM_EP];

  for (genvar g = 0; g < NUM_EP; g++) begin : gEp
    logic [SLOT_BITS-1:0] mask;
    logic                 enabled;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intervalQ[g] <= '1;
        phaseQ[g]    <= '0;
      end else if (epWrEn && epWrIdx == IDX_W'(g)) begin
        intervalQ[g] <= epWrInterval;
        phaseQ[g]    <= epWrPhase;
      end
    end

    always_comb begin
      enabled  = (intervalQ[g] <= CODE_W'(MAX_CODE));
      mask     = ~({SLOT_BITS{1'b1}} << intervalQ[g]);
      dueNow[g] = enabled && (((frameSlot ^ phaseQ[g]) & mask) == '0);
    end
  end
endmodule

// File: rtl/pollDatapath.sv
module pollDatapath
  import pollPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FRAME_W = 16,
  parameter int NUM_EP  = 8,
  localparam int IDX_W      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int ALIGN_BITS = SLOT_BITS + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 baseWrEn,
  input  logic [ADDR_W-1:0]    baseWrData,
  input  logic                 epWrEn,
  input  logic [IDX_W-1:0]     epWrIdx,
  input  logic [CODE_W-1:0]    epWrInterval,
  input  logic [SLOT_BITS-1:0] epWrPhase,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [SLOT_BITS-1:0] leafPos,
  output logic [FRAME_W-1:0]   frameNum,
  output logic [NUM_EP-1:0]    dueVec
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  logic [ADDR_W-1:0]    baseReg;
  logic [SLOT_BITS-1:0] frameSlot;
  logic [SLOT_BITS-1:0] slotRev;
  logic [NUM_EP-1:0]    dueNow;
  logic [ADDR_W-1:0]    entryAddr;

  assign frameSlot = frameNum[SLOT_BITS-1:0];

  for (genvar b = 0; b < SLOT_BITS; b++) begin : gRev
    assign slotRev[b] = frameSlot[SLOT_BITS-1-b];
  end

  assign entryAddr = (baseReg & ~ALIGN_MASK) | ADDR_W'({frameSlot, 2'b00});

  pollDueTable #(.NUM_EP(NUM_EP)) u_dueTable (
    .clk          (clk),
    .rstN         (rstN),
    .epWrEn       (epWrEn),
    .epWrIdx      (epWrIdx),
    .epWrInterval (epWrInterval),
    .epWrPhase    (epWrPhase),
    .frameSlot    (frameSlot),
    .dueNow       (dueNow)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameNum <= '0;
      baseReg  <= '0;
      rdAddr   <= '0;
      leafPos  <= '0;
      dueVec   <= '0;
    end else begin
      if (strobes.incFrame) frameNum <= frameNum + FRAME_W'(1);
      if (baseWrEn) baseReg <= baseWrData;
      if (strobes.capture) begin
        rdAddr  <= entryAddr;
        leafPos <= slotRev;
        dueVec  <= dueNow;
      end else begin
        dueVec  <= '0;
      end
    end
  end
endmodule

// File: rtl/pollSched.sv
module pollSched
  import pollPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int FRAME_W = 16,
  parameter int NUM_EP  = 8,
  localparam int IDX_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameTick,
  input  logic                 baseWrEn,
  input  logic [ADDR_W-1:0]    baseWrData,
  input  logic                 epWrEn,
  input  logic [IDX_W-1:0]     epWrIdx,
  input  logic [CODE_W-1:0]    epWrInterval,
  input  logic [SLOT_BITS-1:0] epWrPhase,
  input  logic                 rdAck,
  output logic                 rdReq,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [SLOT_BITS-1:0] leafPos,
  output logic [FRAME_W-1:0]   frameNum,
  output logic                 dueValid,
  output logic [NUM_EP-1:0]    dueVec
);
  ctrlStrobes_t strobes;

  pollCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameTick (frameTick),
    .rdAck     (rdAck),
    .strobes   (strobes),
    .rdReq     (rdReq),
    .dueValid  (dueValid)
  );

  pollDatapath #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .NUM_EP(NUM_EP)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .baseWrEn     (baseWrEn),
    .baseWrData   (baseWrData),
    .epWrEn       (epWrEn),
    .epWrIdx      (epWrIdx),
    .epWrInterval (epWrInterval),
    .epWrPhase    (epWrPhase),
    .rdAddr       (rdAddr),
    .leafPos      (leafPos),
    .frameNum     (frameNum),
    .dueVec       (dueVec)
  );
endmodule

// File: rtl/pollSchedChk.sv
module pollSchedChk #(
  parameter int ADDR_W  = 32,
  parameter int FRAME_W = 16,
  parameter int NUM_EP  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameTick,
  input logic               rdAck,
  input logic               rdReq,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [FRAME_W-1:0] frameNum,
  input logic               dueValid,
  input logic [NUM_EP-1:0]  dueVec
);
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> frameNum == $past(frameNum) + FRAME_W'(1)); // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(frameNum)); // R2
  AST_DUE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dueValid) |-> $past(frameTick, 2)); // R3
  AST_DUE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dueValid |-> dueVec == '0); // R3
  AST_REQ_WITH_DUE: assert property (@(posedge clk) disable iff (!rstN)
    dueValid |-> rdReq); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq); // R5
  AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck && !$past(frameTick)) |=> $stable(rdAddr)); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck && !$past(frameTick)) |=> !rdReq); // R5
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> rdAddr[1:0] == 2'b00); // R4
endmodule

bind pollSched pollSchedChk #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .NUM_EP(NUM_EP)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameTick (frameTick),
  .rdAck     (rdAck),
  .rdReq     (rdReq),
  .rdAddr    (rdAddr),
  .frameNum  (frameNum),
  .dueValid  (dueValid),
  .dueVec    (dueVec)
);

// File: tb/pollSched_tb.sv
`timescale 1ns/1ps
module pollSched_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameTick = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        epWrEn = 1'b0;
  logic [2:0]  epWrIdx = '0;
  logic [2:0]  epWrInterval = '0;
  logic [4:0]  epWrPhase = '0;
  logic        rdAck = 1'b0;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic [4:0]  leafPos;
  logic [15:0] frameNum;
  logic        dueValid;
  logic [7:0]  dueVec;

  int checks = 0;
  int failures = 0;
  int expFrame = 0;
  logic [31:0] expBase = '0;
  int epCode [8];
  int epPhase [8];

  always #2 clk = ~clk;

  pollSched u_dut (
    .clk(clk), .rstN(rstN), .frameTick(frameTick),
    .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .epWrEn(epWrEn), .epWrIdx(epWrIdx), .epWrInterval(epWrInterval),
    .epWrPhase(epWrPhase), .rdAck(rdAck), .rdReq(rdReq), .rdAddr(rdAddr),
    .leafPos(leafPos), .frameNum(frameNum), .dueValid(dueValid), .dueVec(dueVec)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] calcDue(input int frame);
    logic [7:0] v = '0;
    for (int e = 0; e < 8; e++) begin
      if (epCode[e] <= 5) begin
        int m = (1 << epCode[e]) - 1;
        if ((frame & m) == (epPhase[e] & m)) v[e] = 1'b1;
      end
    end
    return v;
  endfunction

  function automatic int revSlot(input int frame);
    int r = 0;
    for (int b = 0; b < 5; b++) if ((frame >> b) & 1) r |= 1 << (4 - b);
    return r;
  endfunction

  function automatic logic [31:0] calcAddr(input int frame);
    return {expBase[31:7], 7'b0} | 32'((frame & 31) * 4);
  endfunction

  task automatic setEp(input int idx, input int code, input int ph);
    @(negedge clk);
    epWrEn = 1'b1; epWrIdx = 3'(idx); epWrInterval = 3'(code); epWrPhase = 5'(ph);
    @(negedge clk);
    epWrEn = 1'b0;
    epCode[idx] = code; epPhase[idx] = ph & 31;
  endtask

  // one tick; at return the cycle with dueValid high is being sampled
  task automatic tickOnly();
    @(negedge clk); frameTick = 1'b1;
    @(negedge clk); frameTick = 1'b0;
    expFrame = (expFrame + 1) % 65536;
    @(negedge clk);
  endtask

  task automatic checkFrameOutputs(input string tag);
    chk("R3", {tag, " dueValid"}, dueValid, 1);
    chk("R5", {tag, " rdReq"}, rdReq, 1);
    chk("R2", {tag, " frameNum"}, frameNum, expFrame);
    chk("R4", {tag, " rdAddr"}, rdAddr, calcAddr(expFrame));
    chk("R9", {tag, " leafPos"}, leafPos, revSlot(expFrame));
    chk("R7", {tag, " dueVec"}, dueVec, calcDue(expFrame));
  endtask

  task automatic ackNow();
    rdAck = 1'b1;
    @(negedge clk); rdAck = 1'b0;
    chk("R5", "rdReq after ack", rdReq, 0);
    chk("R3", "dueValid one cycle", dueValid, 0);
    chk("R3", "dueVec quiet", dueVec, 0);
  endtask

  task automatic testReset();
    chk("R1", "frameNum", frameNum, 0);
    chk("R1", "rdReq", rdReq, 0);
    chk("R1", "dueValid", dueValid, 0);
    chk("R1", "dueVec", dueVec, 0);
  endtask

  task automatic testBaseAndFirstFrame();
    @(negedge clk); baseWrEn = 1'b1; baseWrData = 32'h1234_56FF;
    @(negedge clk); baseWrEn = 1'b0;
    expBase = 32'h1234_5680;
    tickOnly();
    checkFrameOutputs("first");
    chk("R4", "aligned addr", rdAddr, 32'h1234_5684);
    chk("R9", "leafPos of slot1", leafPos, 16);
    chk("R8", "reset entries disabled", dueVec, 0);
    // hold without ack
    repeat (4) begin
      @(negedge clk);
      chk("R5", "rdReq held", rdReq, 1);
      chk("R5", "rdAddr held", rdAddr, 32'h1234_5684);
    end
    ackNow();
  endtask

  task automatic testEndpointMix();
    setEp(0, 0, 0);
    setEp(1, 1, 1);
    setEp(2, 2, 3);
    setEp(3, 5, 21);
    setEp(4, 6, 0);
    setEp(5, 7, 0);
    setEp(6, 3, 29);
    setEp(7, 4, 9);
    for (int i = 0; i < 64; i++) begin
      tickOnly();
      checkFrameOutputs("mix");
      if (epCode[4] == 6) chk("R8", "codes 6/7 never due", dueVec[5:4], 0);
      ackNow();
    end
  endtask

  task automatic testRewrite();
    setEp(0, 7, 0);
    setEp(3, 0, 0);
    tickOnly();
    checkFrameOutputs("rewrite");
    chk("R10", "ep0 disabled", dueVec[0], 0);
    chk("R10", "ep3 every frame", dueVec[3], 1);
    ackNow();
  endtask

  task automatic testOverwrite();
    tickOnly();
    checkFrameOutputs("pend1");
    tickOnly();
    checkFrameOutputs("pend2");
    chk("R6", "rdReq kept", rdReq, 1);
    chk("R6", "addr moved", rdAddr, calcAddr(expFrame));
    ackNow();
  endtask

  task automatic testWrap();
    int n = 65536 - expFrame;
    @(negedge clk); frameTick = 1'b1;
    repeat (n) @(negedge clk);
    frameTick = 1'b0;
    expFrame = 0;
    chk("R2", "wrap to zero", frameNum, 0);
    chk("R3", "burst dueValid", dueValid, 1);
    @(negedge clk);
    checkFrameOutputs("wrap");
    chk("R4", "slot0 addr", rdAddr, {expBase[31:7], 7'b0});
    ackNow();
    tickOnly();
    checkFrameOutputs("after wrap");
    chk("R2", "frame one", frameNum, 1);
    ackNow();
  endtask

  initial begin
    for (int e = 0; e < 8; e++) begin epCode[e] = 7; epPhase[e] = 0; end
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBaseAndFirstFrame();
    testEndpointMix();
    testRewrite();
    testOverwrite();
    testWrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule